// File: doc/BRIEF.md
# Three-Digit Decimal Event Counter

This block counts enabled clock cycles in decimal, from 000 up to 999, and then wraps to 000. The value is held as three 4-bit BCD digits. Each digit is a small binary counter that steps only through the codes 0 to 9. A digit that has reached 9 goes back to 0 on its next enabled step, and at that same step it lets the digit above it advance. Every register is updated on the rising clock edge, and no asynchronous clear is used, so the digit outputs never pass briefly through an illegal code.

The user drives `cnt_en` high in every cycle that should be counted. A synchronous clear sets the whole value to zero. A terminal-count flag goes high in the cycle whose enabled count will take the value from 999 back to 000. Other blocks can use this flag to extend the chain or to mark a full rollover.

Top module: `bcd_counter`

## Requirements
- R1: While `clr` is high at a rising edge, all three digits become 0 at that edge, whatever the value of `cnt_en`.
- R2: While `clr` is low and `cnt_en` is low at a rising edge, `bcd_o` keeps its value.
- R3: When `clr` is low and `cnt_en` is high, the units digit (`bcd_o[3:0]`) rises by one at each edge while it is below 9, and it returns from 9 to 0.
- R4: The tens digit (`bcd_o[7:4]`) changes only at an enabled edge where the units digit is 9. The hundreds digit (`bcd_o[11:8]`) changes only at an enabled edge where both the units and tens digits are 9. Each of these digits also goes from 9 back to 0.
- R5: An enabled edge taken while the value is 999 sets all three digits to 0.
- R6: `tc_o` is high, with no clock delay, exactly when `cnt_en` is high and all three digits read 9.
- R7: At every enabled edge where `clr` is low, bit 0 of the units digit inverts.
- R8: A digit never holds a code above 9 (1001) in any cycle after the first clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear to 000. It overrides `cnt_en` |
| cnt_en | input | 1 | Counts one event at this edge |
| bcd_o | output | 12 | Digits as hundreds [11:8], tens [7:4] and units [3:0] |
| tc_o | output | 1 | High when the value is 999 and `cnt_en` is high |

## Verification
The digit outputs change one rising edge after the cycle in which `clr` or `cnt_en` is sampled. The bench therefore drives inputs on the falling edge and compares `bcd_o` 1 ns after the next rising edge, against a decimal model that is advanced by the same rule. `tc_o` is combinational, so it is checked 1 ns after the inputs change, before the edge that consumes them. The sweep covers more than two full rollovers, with enable gaps and a clear applied while counting is enabled.

// File: rtl/bcd_counter_pkg.sv
package bcd_counter_pkg;
    localparam int DIGIT_W   = 4;
    localparam int DIGIT_MAX = 9;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    typedef struct packed {
        bcd_digit_t digit;
    } decade_state_t;

    function automatic logic digit_is_max(bcd_digit_t d);
        return d == bcd_digit_t'(DIGIT_MAX);
    endfunction
endpackage

// File: rtl/bcd_decade.sv
module bcd_decade
    import bcd_counter_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       step_i,
    output bcd_digit_t digit_o,
    output logic       at_max_o
);
    decade_state_t st_d, st_q;

    // Reaching 9 makes the next step load zero; 1010 is never entered.
    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.digit = '0;
        end else if (step_i) begin
            if (digit_is_max(st_q.digit)) begin
                st_d.digit = '0;
            end else begin
                st_d.digit = st_q.digit + bcd_digit_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign digit_o  = st_q.digit;
    assign at_max_o = digit_is_max(st_q.digit);
endmodule

// File: rtl/bcd_carry_chain.sv
module bcd_carry_chain #(
    parameter int NUM_DECADES = 3
) (
    input  logic                   en_i,
    input  logic [NUM_DECADES-1:0] at_max_i,
    output logic [NUM_DECADES-1:0] step_o,
    output logic                   tc_o
);
    assign step_o[0] = en_i;

    genvar gi;
    generate
        for (gi = 1; gi < NUM_DECADES; gi++) begin : g_link
            assign step_o[gi] = step_o[gi-1] & at_max_i[gi-1];
        end
    endgenerate

    assign tc_o = step_o[NUM_DECADES-1] & at_max_i[NUM_DECADES-1];
endmodule

// File: rtl/bcd_counter.sv
module bcd_counter
    import bcd_counter_pkg::*;
#(
    parameter int NUM_DECADES = 3
) (
    input  logic                           clk,
    input  logic                           clr,
    input  logic                           cnt_en,
    output logic [NUM_DECADES*DIGIT_W-1:0] bcd_o,
    output logic                           tc_o
);
    logic [NUM_DECADES-1:0] step;
    logic [NUM_DECADES-1:0] at_max;

    bcd_carry_chain #(.NUM_DECADES(NUM_DECADES)) u_chain (
        .en_i     (cnt_en),
        .at_max_i (at_max),
        .step_o   (step),
        .tc_o     (tc_o)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_DECADES; gi++) begin : g_dec
            bcd_decade u_dec (
                .clk      (clk),
                .clr      (clr),
                .step_i   (step[gi]),
                .digit_o  (bcd_o[gi*DIGIT_W +: DIGIT_W]),
                .at_max_o (at_max[gi])
            );
        end
    endgenerate
endmodule

// File: rtl/bcd_counter_chk.sv
module bcd_counter_chk
    import bcd_counter_pkg::*;
#(
    parameter int NUM_DECADES = 3
) (
    input logic                           clk,
    input logic                           clr,
    input logic                           cnt_en,
    input logic [NUM_DECADES*DIGIT_W-1:0] bcd_o,
    input logic                           tc_o
);
    localparam int W = NUM_DECADES*DIGIT_W;

    function automatic logic all_max(logic [W-1:0] v);
        logic r;
        r = 1'b1;
        for (int k = 0; k < NUM_DECADES; k++) begin
            r &= (v[k*DIGIT_W +: DIGIT_W] == bcd_digit_t'(DIGIT_MAX));
        end
        return r;
    endfunction

    assert_clear_R1: assert property (@(posedge clk) clr |=> bcd_o == '0);

    assert_hold_R2: assert property (@(posedge clk) disable iff (clr)
        !cnt_en |=> $stable(bcd_o));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (clr)
        (cnt_en && all_max(bcd_o)) |=> bcd_o == '0);

    assert_tc_R6: assert property (@(posedge clk) disable iff (clr)
        tc_o |-> (cnt_en && all_max(bcd_o)));

    assert_lsb_R7: assert property (@(posedge clk) disable iff (clr)
        cnt_en |=> bcd_o[0] != $past(bcd_o[0]));

    genvar gi;
    generate
        for (gi = 0; gi < NUM_DECADES; gi++) begin : g_rng
            assert_digit_range_R8: assert property (@(posedge clk) disable iff (clr)
                1'b1 |=> bcd_o[gi*DIGIT_W +: DIGIT_W] <= bcd_digit_t'(DIGIT_MAX));
        end
    endgenerate
endmodule

bind bcd_counter bcd_counter_chk #(.NUM_DECADES(NUM_DECADES)) u_chk (
    .clk    (clk),
    .clr    (clr),
    .cnt_en (cnt_en),
    .bcd_o  (bcd_o),
    .tc_o   (tc_o)
);

// File: tb/tb_bcd_counter.sv
`timescale 1ns/1ps
module tb_bcd_counter;
    logic        clk = 1'b0;
    logic        clr = 1'b1;
    logic        cnt_en = 1'b0;
    logic [11:0] bcd_o;
    logic        tc_o;

    int n_chk  = 0;
    int n_fail = 0;
    int model  = 0;

    always #5 clk = ~clk;

    bcd_counter dut (
        .clk    (clk),
        .clr    (clr),
        .cnt_en (cnt_en),
        .bcd_o  (bcd_o),
        .tc_o   (tc_o)
    );

    function automatic logic [11:0] to_bcd(int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic check(string req, logic [11:0] act, logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(logic c, logic e);
        logic prev_lsb;
        string req;
        @(negedge clk);
        clr = c;
        cnt_en = e;
        #1;
        check("R6 tc_o", {11'd0, tc_o}, {11'd0, e && (model == 999)});
        prev_lsb = bcd_o[0];
        if (c)                  req = "R1 clear";
        else if (!e)            req = "R2 hold";
        else if (model == 999)  req = "R5 wrap";
        else if (model % 10 == 9) req = "R4 carry";
        else                    req = "R3 units";
        @(posedge clk);
        if (c)      model = 0;
        else if (e) model = (model + 1) % 1000;
        #1;
        check(req, bcd_o, to_bcd(model));
        if (!c && e) check("R7 lsb toggle", {11'd0, bcd_o[0]}, {11'd0, ~prev_lsb});
        for (int k = 0; k < 3; k++) begin
            check("R8 digit range", {11'd0, bcd_o[k*4 +: 4] > 4'd9}, 12'd0);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: all requirements, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        // first full sweep, uninterrupted, through 999 and wrap
        for (int i = 0; i < 1005; i++) step(1'b0, 1'b1);
        // second sweep with enable gaps
        for (int i = 0; i < 1400; i++) step(1'b0, (i % 7) != 3);
        // clear while enabled takes priority
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        for (int i = 0; i < 25; i++) step(1'b0, (i % 3) != 0);
        // walk to 999, idle there, then wrap
        while (model != 999) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule